// File: doc/BRIEF.md
# Dense Layer Multiply-Accumulate Engine

This block evaluates one fully connected neural-network layer in fixed point. For every output neuron it forms the bias plus the dot product of that neuron's weight row with the input vector. It can then clamp negative results to zero. Weights, biases and the input vector are held in local storage, and all three are written through a single write port. A start pulse runs the whole layer on one multiplier-accumulator at one product per cycle. One result leaves the block per output neuron, in ascending neuron order, and a done pulse closes the run.

Each instance fixes its shape (inputs, outputs) and its activation choice through parameters. A three-layer classifier chain instantiates 400->120 and 120->84 with the clamp enabled, and 84->10 with the clamp disabled. The 400 inputs of the first layer are a flattened 16x5x5 feature map, with channel as the slowest index, then row, then column. The default elaboration is the 84->10 classifier layer.

Operands are signed 16-bit values with FRAC (default 8) fraction bits. Products are summed in a 40-bit accumulator. The bias is preloaded into the accumulator, aligned to the product scale. The sum is then rounded and saturated back to 16 bits.

Top module: `fc_dense_engine`

## Requirements
- R1: While reset is held and right after it, out_valid, done and busy are low.
- R2: A write with wr_sel 0 stores weight W[o][i] at address o*N_IN+i, so each neuron's row is contiguous. wr_sel 1 stores bias o at address o, and wr_sel 2 stores input i at address i. wr_sel 3 changes nothing.
- R3: Output o equals bias[o] + sum over i of W[o][i]*x[i], with the bias taken at output scale and the products taken at twice the fraction bits.
- R4: The scaled sum is rounded half up: 2^(FRAC-1) is added before an arithmetic right shift by FRAC.
- R5: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R6: With RELU_EN set, a negative result is output as 0. With RELU_EN clear, negative results pass unchanged.
- R7: The edge that samples start is cycle 0. Result k appears with out_idx = k and out_valid high for exactly one cycle, (k+1)*N_IN cycles after that edge.
- R8: done is high for exactly one cycle, one cycle after the last result (N_OUT*N_IN+1 cycles after the start edge).
- R9: A start pulse while busy is ignored, and the run's results and timing are unchanged.
- R10: busy rises in the cycle after an accepted start and falls in the same cycle as done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the local storage |
| wr_sel | input | 2 | Storage select: 0 weight, 1 bias, 2 input, 3 none |
| wr_addr | input | clog2(N_IN*N_OUT) | Write address within the selected storage |
| wr_data | input | 16 | Signed fixed-point value to store |
| start | input | 1 | Begin a layer evaluation |
| busy | output | 1 | Evaluation in progress |
| out_valid | output | 1 | out_data and out_idx hold a result |
| out_idx | output | clog2(N_OUT) | Output neuron index of the result |
| out_data | output | 16 | Signed fixed-point result |
| done | output | 1 | One-cycle pulse after the last result |

## Verification
All cycle counts are taken from the edge that samples start. The result of neuron k is due (k+1)*N_IN cycles after that edge, and done is due N_OUT*N_IN+1 cycles after it. The bench keeps a free-running cycle count and samples every output on the falling edge. It stores the value, the index and the cycle of each result, then compares each against the due cycle and against a value computed by a bench model of the rounding, saturation and clamp rules. Ignored starts are injected mid-run, and the recorded timing of that run must still match the undisturbed schedule.

// File: rtl/fc_dense_engine.sv
module fc_dense_engine #(
  parameter int N_IN    = 84,
  parameter int N_OUT   = 10,
  parameter int DW      = 16,
  parameter int FRAC    = 8,
  parameter int ACC_W   = 40,
  parameter int RELU_EN = 0,
  localparam int WDEPTH = N_IN * N_OUT,
  localparam int WAW    = $clog2(WDEPTH),
  localparam int IW     = $clog2(N_IN),
  localparam int OW     = $clog2(N_OUT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [WAW-1:0]       wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 start,
  output logic                 busy,
  output logic                 out_valid,
  output logic [OW-1:0]        out_idx,
  output logic signed [DW-1:0] out_data,
  output logic                 done
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  logic signed [DW-1:0] wmem [WDEPTH];
  logic signed [DW-1:0] bmem [N_OUT];
  logic signed [DW-1:0] xmem [N_IN];

  logic [WAW-1:0] wptr;
  logic [IW-1:0]  icnt;
  logic [OW-1:0]  ocnt;
  logic signed [ACC_W-1:0] acc, acc_nx, rnd, shf;
  logic signed [2*DW-1:0]  prod;
  logic signed [DW-1:0]    sat, fin;
  logic ovf_pos, ovf_neg;

  function automatic logic signed [ACC_W-1:0] bext(input logic signed [DW-1:0] b);
    return {{(ACC_W-DW-FRAC){b[DW-1]}}, b, {FRAC{1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (wr_sel)
        2'd0: if (32'(wr_addr) < WDEPTH) wmem[wr_addr] <= wr_data;
        2'd1: if (32'(wr_addr) < N_OUT) bmem[wr_addr[OW-1:0]] <= wr_data;
        2'd2: if (32'(wr_addr) < N_IN) xmem[wr_addr[IW-1:0]] <= wr_data;
        default: ;
      endcase
    end
  end

  assign prod    = wmem[wptr] * xmem[icnt];
  assign acc_nx  = acc + {{(ACC_W-2*DW){prod[2*DW-1]}}, prod};
  assign rnd     = acc_nx + (ACC_W'(1) << (FRAC-1));
  assign shf     = rnd >>> FRAC;
  assign ovf_pos = !shf[ACC_W-1] && (|shf[ACC_W-2:DW-1]);
  assign ovf_neg = shf[ACC_W-1] && !(&shf[ACC_W-2:DW-1]);
  assign sat     = ovf_pos ? {1'b0, {(DW-1){1'b1}}} :
                   ovf_neg ? {1'b1, {(DW-1){1'b0}}} : shf[DW-1:0];
  assign fin     = (RELU_EN != 0 && sat[DW-1]) ? '0 : sat;
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      out_valid <= 1'b0;
      done      <= 1'b0;
      out_data  <= '0;
      out_idx   <= '0;
      acc       <= '0;
      wptr      <= '0;
      icnt      <= '0;
      ocnt      <= '0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_RUN;
          acc  <= bext(bmem[0]);
          wptr <= '0;
          icnt <= '0;
          ocnt <= '0;
        end
        S_RUN: begin
          wptr <= wptr + 1'b1;
          if (icnt == IW'(N_IN-1)) begin
            out_valid <= 1'b1;
            out_data  <= fin;
            out_idx   <= ocnt;
            icnt      <= '0;
            if (ocnt == OW'(N_OUT-1)) begin
              st <= S_FIN;
            end else begin
              ocnt <= ocnt + 1'b1;
              acc  <= bext(bmem[ocnt + OW'(1)]);
            end
          end else begin
            acc  <= acc_nx;
            icnt <= icnt + 1'b1;
          end
        end
        S_FIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid) && $past(out_idx) == OW'(N_OUT-1) && !busy));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  relu_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && RELU_EN != 0) |-> !out_data[DW-1]);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && icnt != IW'(N_IN-1)) |=> (st == S_RUN && icnt == $past(icnt) + 1'b1));

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !out_valid));

endmodule

// File: tb/tb_fc_dense_engine.sv
module tb_fc_dense_engine;
  localparam int NI = 84, NO = 10, WAW = $clog2(NI*NO), OW = $clog2(NO);
  localparam int RNI = 8, RNO = 4, RWAW = $clog2(RNI*RNO), ROW = $clog2(RNO);

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic wr_en = 0, start = 0;
  logic [1:0] wr_sel = 0;
  logic [WAW-1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic busy, out_valid, done;
  logic [OW-1:0] out_idx;
  logic signed [15:0] out_data;

  logic r_wr_en = 0, r_start = 0;
  logic [1:0] r_wr_sel = 0;
  logic [RWAW-1:0] r_wr_addr = 0;
  logic [15:0] r_wr_data = 0;
  logic r_busy, r_out_valid, r_done;
  logic [ROW-1:0] r_out_idx;
  logic signed [15:0] r_out_data;

  fc_dense_engine #(.N_IN(NI), .N_OUT(NO)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .busy(busy), .out_valid(out_valid),
    .out_idx(out_idx), .out_data(out_data), .done(done));

  fc_dense_engine #(.N_IN(RNI), .N_OUT(RNO), .RELU_EN(1)) dut_r (
    .clk(clk), .rst_n(rst_n), .wr_en(r_wr_en), .wr_sel(r_wr_sel), .wr_addr(r_wr_addr),
    .wr_data(r_wr_data), .start(r_start), .busy(r_busy), .out_valid(r_out_valid),
    .out_idx(r_out_idx), .out_data(r_out_data), .done(r_done));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int bw[NI*NO], bb[NO], bx[NI];
  int g_val[NO], g_idx[NO], g_cyc[NO];
  int g_cnt, d_cnt, d_cyc, r_cnt;
  int r_val[RNO];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid) begin
      if (g_cnt < NO) begin
        g_val[g_cnt] = int'(out_data);
        g_idx[g_cnt] = int'(out_idx);
        g_cyc[g_cnt] = cyc;
      end
      g_cnt++;
    end
    if (done) begin
      d_cnt++;
      d_cyc = cyc;
    end
    if (r_out_valid) begin
      if (r_cnt < RNO) r_val[r_cnt] = int'(r_out_data);
      r_cnt++;
    end
  end

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int model(int o);
    longint acc = longint'(bb[o]) <<< 8;
    for (int i = 0; i < NI; i++) acc += longint'(bw[o*NI+i]) * longint'(bx[i]);
    acc = (acc + 128) >>> 8;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  function automatic int rnd(int r);
    return int'($urandom_range(2*r, 0)) - r;
  endfunction

  task automatic fill_rand(int wr, int xr, int br);
    for (int k = 0; k < NI*NO; k++) bw[k] = rnd(wr);
    for (int k = 0; k < NI; k++) bx[k] = rnd(xr);
    for (int k = 0; k < NO; k++) bb[k] = rnd(br);
  endtask

  task automatic clear_all();
    for (int k = 0; k < NI*NO; k++) bw[k] = 0;
    for (int k = 0; k < NI; k++) bx[k] = 0;
    for (int k = 0; k < NO; k++) bb[k] = 0;
  endtask

  task automatic wr(logic [1:0] sel, int addr, int data);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_addr = addr[WAW-1:0]; wr_data = data[15:0];
  endtask

  task automatic load_all();
    for (int k = 0; k < NI*NO; k++) wr(2'd0, k, bw[k]);
    for (int k = 0; k < NO; k++) wr(2'd1, k, bb[k]);
    for (int k = 0; k < NI; k++) wr(2'd2, k, bx[k]);
    @(negedge clk) wr_en = 0;
  endtask

  task automatic run(string tag, int restart_at);
    int c0;
    g_cnt = 0; d_cnt = 0; d_cyc = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    c0 = cyc;
    check({tag, " R10 busy after start"}, int'(busy), 1);
    if (restart_at > 0) begin
      repeat (restart_at) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    for (int w = 0; w < NI*NO + 40 && d_cnt == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    check({tag, " R7 result count"}, g_cnt, NO);
    for (int k = 0; k < NO; k++) begin
      check({tag, " R3 value"}, g_val[k], model(k));
      check({tag, " R7 index"}, g_idx[k], k);
      check({tag, " R7 cycle"}, g_cyc[k] - c0, (k+1)*NI);
    end
    check({tag, " R8 done count"}, d_cnt, 1);
    check({tag, " R8 done cycle"}, d_cyc - c0, NO*NI + 1);
    check({tag, " R10 busy low after done"}, int'(busy), 0);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 busy in reset", int'(busy), 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 out_valid after reset", int'(out_valid), 0);

    // R2: diagonal weight layout, plus a write with the unused select
    clear_all();
    for (int o = 0; o < NO; o++) bw[o*NI + o] = 256;
    for (int i = 0; i < NI; i++) bx[i] = i*3 - 50;
    load_all();
    wr(2'd3, 0, 16'h7fff);
    wr(2'd3, 1, 16'h1234);
    @(negedge clk) wr_en = 0;
    run("R2", 0);
    for (int o = 0; o < NO; o++) check("R2 row layout", g_val[o], o*3 - 50);
    check("R6 no clamp on default instance", g_val[0], -50);

    // R3: random operands
    for (int t = 0; t < 3; t++) begin
      fill_rand(300, 300, 2000);
      load_all();
      run("R3 random", 0);
    end

    // R4: rounding half up
    clear_all();
    bw[0*NI+0] = 1; bx[0] = 128;
    bw[1*NI+1] = 1; bx[1] = -128;
    bw[2*NI+2] = 1; bx[2] = 127;
    bw[3*NI+3] = 1; bx[3] = -129;
    bw[4*NI+4] = 1; bx[4] = 384;
    load_all();
    run("R4", 0);
    check("R4 +0.5 rounds up", g_val[0], 1);
    check("R4 -0.5 rounds up", g_val[1], 0);
    check("R4 below half", g_val[2], 0);
    check("R4 past -half", g_val[3], -1);
    check("R4 +1.5", g_val[4], 2);

    // R5: saturation both ways
    for (int o = 0; o < NO; o++) begin
      bb[o] = (o % 2 == 0) ? 32767 : -32768;
      for (int i = 0; i < NI; i++) bw[o*NI+i] = (o % 2 == 0) ? 32767 : -32768;
    end
    for (int i = 0; i < NI; i++) bx[i] = 32767;
    load_all();
    run("R5", 0);
    for (int o = 0; o < NO; o++) check("R5 saturate", g_val[o], (o % 2 == 0) ? 32767 : -32768);

    // R9: start while busy
    fill_rand(1000, 1000, 5000);
    load_all();
    run("R9 restart mid-run", 100);
    run("R9 restart late", NI*NO - 20);

    // R6: clamp instance
    r_cnt = 0;
    for (int k = 0; k < RNI*RNO; k++) begin
      @(negedge clk) r_wr_en = 1; r_wr_sel = 2'd0; r_wr_addr = RWAW'(k);
      r_wr_data = (k % RNI == 0) ? 16'd256 : 16'd0;
    end
    for (int k = 0; k < RNI; k++) begin
      @(negedge clk) r_wr_en = 1; r_wr_sel = 2'd2; r_wr_addr = RWAW'(k);
      r_wr_data = (k == 0) ? 16'd100 : 16'd7;
    end
    for (int k = 0; k < RNO; k++) begin
      @(negedge clk) r_wr_en = 1; r_wr_sel = 2'd1; r_wr_addr = RWAW'(k);
      case (k)
        0: r_wr_data = 16'(-300);
        1: r_wr_data = 16'd500;
        2: r_wr_data = 16'(-101);
        default: r_wr_data = 16'(-99);
      endcase
    end
    @(negedge clk) r_wr_en = 0; r_start = 1;
    @(negedge clk) r_start = 0;
    repeat (RNI*RNO + 10) @(negedge clk);
    check("R6 clamp count", r_cnt, RNO);
    check("R6 negative clamped", r_val[0], 0);
    check("R6 positive kept", r_val[1], 600);
    check("R6 -1 clamped", r_val[2], 0);
    check("R6 +1 kept", r_val[3], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule